// File: doc/BRIEF.md
# Self-Timed Byte EEPROM Controller

This block sits on a CPU register bus and fronts a 4096-byte nonvolatile store, modelled here as a register array. Software reaches the store through four small registers: a low address byte, a high address nibble, a data byte and a control byte. Each access reads or writes a single byte.

A read is immediate. Software loads the address and sets the read bit. The byte is then copied into the data register, and the CPU is stalled for four cycles.

A write is guarded. Software loads the address and data registers, sets the arm bit, and then sets the write bit while the arm window is still open. The write start stalls the CPU for two cycles. The programming interval is then timed on a separate oscillator clock, and the write bit reads back as one until that interval ends.

The start of a write crosses into the oscillator domain as a toggle. Completion crosses back as a toggle through a two-flop synchronizer. A one-cycle ready pulse marks the end of each write and can serve as an interrupt request. A CPU-side reset clears the software registers but never cuts a write short. Only the power-on reset touches the write path.

Top module: `eeprom_ctrl`

## Requirements
- R1: The store holds 4096 bytes on a 12-bit address. `reg_sel` 0 selects the low address byte and `reg_sel` 1 the high address nibble, whose upper four bits are ignored and read as zero. `reg_sel` 2 selects the data register and `reg_sel` 3 the control register. A byte that is written can be read back at the same address, including addresses 0x000 and 0xFFF.
- R2: A write starts only if control bit 2 (arm) was written first, followed by control bit 1 (write) within the window. Writing bit 1 with no arm in force starts nothing.
- R3: Control bit 2 reads back as one for the 4 cycles after arming and then clears by itself. A write bit set on the first through fourth cycle after arming starts a write. A write bit set on the fifth cycle after arming is ignored.
- R4: From the cycle after a write start until programming ends, control bit 1 and `busy_o` are one. The interval lasts 26368 oscillator cycles plus the synchronizer latency.
- R5: Writing control bit 0 (read) loads the data register with the byte at the current address. Control bit 0 always reads back as zero.
- R6: A read start holds `stall_o` high for exactly 4 CPU cycles.
- R7: A write start holds `stall_o` high for exactly 2 CPU cycles.
- R8: While a write is busy, read, arm and write requests are ignored: no stall, no new write, and the data register keeps its value.
- R9: When a write completes, control bit 1 clears and `ready_o` is high for exactly one cycle.
- R10: Asserting `rst_n` during a write clears the address, data, arm and stall state, but the write still completes and stores its byte.
- R11: After reset the control register, the data register, `busy_o`, `stall_o` and `ready_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | CPU reset, active low; clears software registers only |
| por_n | input | 1 | Power-on reset, active low; clears the write path in both domains |
| osc_clk | input | 1 | Calibrated oscillator clock that times programming |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 addr low, 1 addr high, 2 data, 3 control) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| stall_o | output | 1 | CPU stall request |
| busy_o | output | 1 | Write in progress |
| ready_o | output | 1 | One-cycle pulse at write completion |

## Verification
The bench probes the edges of the arm window. It sets the write bit on the fourth cycle after arming, which must start a write, and on the fifth, which must not. A design with an off-by-one window would either drop the legal write or program a byte that was never intended.

It issues a second write and a read while programming is under way. A controller that failed to block them would overwrite the target byte or clobber the data register.

It pulses the CPU reset mid-write and then reads the byte back. A design that tied the write path to that reset would lose the byte or leave the busy flag stuck.

It also measures the stall lengths and the busy interval in oscillator cycles. This catches stall counts that are swapped between reads and writes, and a programming counter with the wrong terminal count.

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 26368,
  parameter int ARM_WINDOW  = 4,
  parameter int RD_STALL    = 4,
  parameter int WR_STALL    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              osc_clk,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              stall_o,
  output logic              busy_o,
  output logic              ready_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - DATA_W;
  localparam int CNT_W = $clog2(PROG_CYCLES);
  localparam int ARM_W = $clog2(ARM_WINDOW + 1);
  localparam int ST_W  = $clog2(RD_STALL + WR_STALL + 1);
  localparam logic [1:0] SEL_ALO = 2'd0, SEL_AHI = 2'd1, SEL_DAT = 2'd2, SEL_CTL = 2'd3;
  localparam int BIT_RD = 0, BIT_WR = 1, BIT_ARM = 2;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [ARM_W-1:0]  arm_q;
  logic [ST_W-1:0]   stall_q;
  logic [ADDR_W-1:0] wa_q;
  logic [DATA_W-1:0] wd_q;
  logic              req_q, ack_s1, ack_s2, busy_q;
  logic              req_s1, req_s2, seen_q, act_q, ack_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] mem [DEPTH];

  wire ctl_wr   = reg_we && (reg_sel == SEL_CTL);
  wire arm_open = (arm_q != '0);
  wire wr_start = ctl_wr && reg_wdata[BIT_WR] && arm_open && !busy_o;
  wire rd_start = ctl_wr && reg_wdata[BIT_RD] && !wr_start && !busy_o;
  wire arm_set  = ctl_wr && reg_wdata[BIT_ARM] && !wr_start && !busy_o;

  assign busy_o  = req_q ^ ack_s2;
  assign ready_o = busy_q & ~busy_o;
  assign stall_o = (stall_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      data_q  <= '0;
      arm_q   <= '0;
      stall_q <= '0;
    end else begin
      if (reg_we && reg_sel == SEL_ALO) addr_q[DATA_W-1:0] <= reg_wdata;
      if (reg_we && reg_sel == SEL_AHI) addr_q[ADDR_W-1:DATA_W] <= reg_wdata[HI_W-1:0];
      if (reg_we && reg_sel == SEL_DAT) data_q <= reg_wdata;
      else if (rd_start)                data_q <= mem[addr_q];
      if (wr_start)      arm_q <= '0;
      else if (arm_set)  arm_q <= ARM_W'(ARM_WINDOW);
      else if (arm_open) arm_q <= arm_q - 1'b1;
      if (rd_start)             stall_q <= ST_W'(RD_STALL);
      else if (wr_start)        stall_q <= ST_W'(WR_STALL);
      else if (stall_q != '0)   stall_q <= stall_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      req_q  <= 1'b0;
      wa_q   <= '0;
      wd_q   <= '0;
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (wr_start) begin
        req_q <= ~req_q;
        wa_q  <= addr_q;
        wd_q  <= data_q;
      end
      ack_s1 <= ack_q;
      ack_s2 <= ack_s1;
      busy_q <= busy_o;
    end
  end

  always_ff @(posedge osc_clk or negedge por_n) begin
    if (!por_n) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
      seen_q <= 1'b0;
      act_q  <= 1'b0;
      ack_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      req_s1 <= req_q;
      req_s2 <= req_s1;
      if (act_q) begin
        if (cnt_q == '0) begin
          act_q <= 1'b0;
          ack_q <= ~ack_q;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (req_s2 != seen_q) begin
        seen_q <= req_s2;
        act_q  <= 1'b1;
        cnt_q  <= CNT_W'(PROG_CYCLES - 1);
      end
    end
  end

  always_ff @(posedge osc_clk) begin
    if (act_q && cnt_q == '0) mem[wa_q] <= wd_q;
  end

  always_comb begin
    case (reg_sel)
      SEL_ALO: reg_rdata = addr_q[DATA_W-1:0];
      SEL_AHI: reg_rdata = DATA_W'(addr_q[ADDR_W-1:DATA_W]);
      SEL_DAT: reg_rdata = data_q;
      default: begin
        reg_rdata          = '0;
        reg_rdata[BIT_WR]  = busy_o;
        reg_rdata[BIT_ARM] = arm_open;
      end
    endcase
  end

  a_r2_start_needs_arm: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(busy_o) |-> $past(arm_open));
  a_r6_read_stall: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    rd_start |=> stall_o);
  a_r7_write_stall: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    wr_start |=> (stall_o && busy_o));
  a_r9_ready_one_cycle: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    ready_o |=> !ready_o);
  a_r8_busy_holds_data: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (busy_o && !(reg_we && reg_sel == SEL_DAT)) |=> $stable(data_q));
endmodule

// File: tb/tb_eeprom_ctrl.sv
module tb_eeprom_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int OSC_PERIOD = 7;
  localparam int PROG       = 26368;

  logic clk = 0, osc_clk = 0, rst_n = 0, por_n = 0;
  logic reg_we = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic stall_o, busy_o, ready_o;

  int tests = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_val;
  event       got_ev;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(OSC_PERIOD/2.0) osc_clk = ~osc_clk;

  eeprom_ctrl dut (.clk(clk), .rst_n(rst_n), .por_n(por_n), .osc_clk(osc_clk),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .stall_o(stall_o), .busy_o(busy_o), .ready_o(ready_o));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] sel, input logic [7:0] val);
    reg_we = 1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic reg_rd(input logic [1:0] sel, output logic [7:0] v);
    reg_sel = sel; #1; v = reg_rdata;
  endtask

  task automatic set_addr(input logic [11:0] a);
    reg_wr(2'd0, a[7:0]);
    reg_wr(2'd1, {4'h0, a[11:8]});
  endtask

  task automatic start_write(input logic [11:0] a, input logic [7:0] d);
    int n;
    set_addr(a);
    reg_wr(2'd2, d);
    reg_wr(2'd3, 8'h04);
    reg_wr(2'd3, 8'h02);
    n = 0;
    while (stall_o) begin n++; @(negedge clk); end
    check(n == 2, "R7 write stall cycles", n, 2);
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    while (busy_o) @(negedge clk);
    check(ready_o == 1'b1, "R9 ready pulse at completion", ready_o, 1);
    reg_rd(2'd3, v);
    check(v[1] == 1'b0, "R9 write bit cleared", v[1], 0);
    @(negedge clk);
    check(ready_o == 1'b0, "R9 ready lasts one cycle", ready_o, 0);
  endtask

  task automatic do_read(input logic [11:0] a, input logic [7:0] exp, input string tag);
    int n;
    logic [7:0] v;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    set_addr(a);
    reg_wr(2'd3, 8'h01);
    n = 0;
    while (stall_o) begin n++; @(negedge clk); end
    check(n == 4, "R6 read stall cycles", n, 4);
    reg_rd(2'd3, v);
    check(v[0] == 1'b0, "R5 read bit reads zero", v[0], 0);
    reg_rd(2'd2, v);
    got_val = v;
    -> got_ev;
    #1;
  endtask

  initial begin
    forever begin
      @(got_ev);
      if (exp_q.size() == 0) begin
        check(0, "R1 scoreboard underflow", 0, 1);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(got_val == e, t, got_val, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    @(negedge clk);

    check(busy_o == 0 && stall_o == 0 && ready_o == 0, "R11 reset outputs", {busy_o, stall_o, ready_o}, 0);
    reg_rd(2'd3, v); check(v == 8'h00, "R11 reset control", v, 0);
    reg_rd(2'd2, v); check(v == 8'h00, "R11 reset data", v, 0);

    reg_wr(2'd1, 8'hFF);
    reg_rd(2'd1, v); check(v == 8'h0F, "R1 high address nibble", v, 8'h0F);

    reg_wr(2'd3, 8'h02);
    @(negedge clk);
    check(busy_o == 0, "R2 write without arm ignored", busy_o, 0);

    set_addr(12'h000);
    reg_wr(2'd2, 8'hA5);
    reg_wr(2'd3, 8'h04);
    reg_rd(2'd3, v); check(v[2] == 1'b1, "R3 arm bit set", v[2], 1);
    reg_wr(2'd3, 8'h02);
    n = 0;
    while (stall_o) begin n++; @(negedge clk); end
    check(n == 2, "R7 write stall cycles", n, 2);
    reg_rd(2'd3, v); check(v[1] == 1'b1, "R4 write bit while busy", v[1], 1);
    n = 0;
    while (busy_o) begin @(posedge osc_clk); n++; end
    check(n >= PROG + 2 && n <= PROG + 8, "R4 busy interval in oscillator cycles", n, PROG + 5);
    @(negedge clk); @(negedge clk);
    do_read(12'h000, 8'hA5, "R1 read back addr 0x000");

    start_write(12'hFFF, 8'h3C);
    wait_idle();
    do_read(12'hFFF, 8'h3C, "R1 read back addr 0xFFF");

    set_addr(12'h321);
    reg_wr(2'd2, 8'h44);
    reg_wr(2'd3, 8'h04);
    repeat (4) @(negedge clk);
    reg_rd(2'd3, v); check(v[2] == 1'b0, "R3 arm bit self-clears", v[2], 0);
    reg_wr(2'd3, 8'h02);
    check(busy_o == 0, "R3 write on fifth cycle ignored", busy_o, 0);

    set_addr(12'h123);
    reg_wr(2'd2, 8'h7E);
    reg_wr(2'd3, 8'h04);
    repeat (3) @(negedge clk);
    reg_wr(2'd3, 8'h02);
    check(busy_o == 1, "R3 write on fourth cycle starts", busy_o, 1);
    wait_idle();
    do_read(12'h123, 8'h7E, "R3 window write stored");

    start_write(12'h789, 8'h11);
    set_addr(12'h000);
    reg_wr(2'd2, 8'h99);
    reg_wr(2'd3, 8'h04);
    reg_wr(2'd3, 8'h02);
    check(stall_o == 0, "R8 no stall for write while busy", stall_o, 0);
    reg_wr(2'd3, 8'h01);
    check(stall_o == 0, "R8 no stall for read while busy", stall_o, 0);
    reg_rd(2'd2, v); check(v == 8'h99, "R8 data register unchanged", v, 8'h99);
    reg_rd(2'd3, v); check(v[2] == 1'b0, "R8 arm ignored while busy", v[2], 0);
    wait_idle();
    @(negedge clk);
    check(busy_o == 0, "R8 no queued second write", busy_o, 0);
    do_read(12'h000, 8'hA5, "R8 blocked write left byte intact");
    do_read(12'h789, 8'h11, "R8 first write stored");

    start_write(12'h456, 8'hC3);
    repeat (100) @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy_o == 1, "R10 busy survives CPU reset", busy_o, 1);
    reg_rd(2'd0, v); check(v == 8'h00, "R10 address cleared by reset", v, 0);
    wait_idle();
    do_read(12'h456, 8'hC3, "R10 write completed through reset");

    @(negedge clk);
    check(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule